// File: doc/BRIEF.md
# Next-PC Sequencer for a Single-Cycle Fetch Stage

This block owns the program counter of a single-cycle processor. It presents the current PC as the instruction address. On every rising clock edge it loads one of three candidates. The first is the sequential successor PC + 4. The second is a PC-relative branch target built from a signed 16-bit word offset. The third is a pseudo-direct jump target, built from a 26-bit word index placed inside the current 256 MB region.

The decoder supplies two controls. One says whether the instruction is a conditional branch. The other says whether it is a jump. The datapath supplies an equality flag, which it forms by subtracting the two register operands and testing for zero. A branch is taken only when the branch control and the equality flag are both high. The jump selection is applied after the branch choice, so it overrides it.

The reset input is asynchronous and active low. Its release is passed through a synchronizer, so the PC starts to advance a fixed number of edges after the reset pin rises.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0x00000000, and pulling `rst_n` low clears it without waiting for a clock edge. After `rst_n` rises between two edges, `pc` stays 0 through the next two rising edges and first changes on the third.
- R2: When `jmp` is 0 and `br_sel` is 0, the next PC is PC + 4.
- R3: When `br_sel` = 1, `eq` = 1 and `jmp` = 0, the next PC is PC + 4 + (`imm16` sign-extended from bit 15, times 4). `imm16` = 0x8000 therefore means -32768 words.
- R4: When `br_sel` is 0, the value of `eq` has no effect. The PC advances by 4 whether `eq` is 0 or 1.
- R5: When `br_sel` = 1 and `eq` = 0 (with `jmp` = 0), the branch is not taken and the PC advances by 4.
- R6: When `jmp` is 1, the next PC is {PC[31:28], `jtarget`[25:0], 2'b00}. This holds for any value of `br_sel`, `eq` and `imm16`.
- R7: The four region bits of a jump come from the current PC, not from PC + 4. A jump at 0x0FFFFFFC with target 5 lands at 0x00000014.
- R8: All PC arithmetic wraps modulo 2^32, both for the sequential step and for the branch target.
- R9: The two low bits of `pc` are always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| br_sel | input | 1 | 1 when the current instruction is a conditional branch |
| eq | input | 1 | Equality flag from the datapath (the register operands compare equal) |
| jmp | input | 1 | 1 when the current instruction is a pseudo-direct jump |
| imm16 | input | 16 | Signed branch offset, counted in words |
| jtarget | input | 26 | Jump target word index |
| pc | output | 32 | Current program counter and instruction address |

## Verification
The embedded properties check every cycle. They cover the sequential step, the taken-branch target, the fact that the flag has no effect without a branch, the jump splice with its region bits taken from the previous PC, word alignment, and the zero PC during reset.

Other behaviour can only be shown by the bench's scenarios. These are:
- the exact count of edges between the reset pin rising and the first PC update;
- the asynchronous clear in the middle of a cycle;
- wrap-around at the top and bottom of the address space;
- the region boundary, where PC + 4 and the current PC have different upper bits.

The bench sweeps all eight control combinations against boundary and spread-out offsets and targets.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // Which candidate the next-PC mux forwards
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2
  } npc_src_e;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a one in from the bottom; the top stage drives the internal reset
  generate
    if (STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int ADDR_W  = 32,
  parameter int IMM_W   = 16,
  parameter int TGT_W   = 26,
  parameter int ALIGN_W = 2
) (
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [IMM_W-1:0]  offs,
  input  logic [TGT_W-1:0]  tgt,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] br_pc,
  output logic [ADDR_W-1:0] jmp_pc
);

  localparam int PAGE_W = ADDR_W - TGT_W - ALIGN_W;
  localparam int EXT_W  = ADDR_W - IMM_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

  logic [ADDR_W-1:0] offs_bytes;

  // Sign-extend the word offset and scale it to bytes
  generate
    if (EXT_W > 0) begin : g_sext
      always_comb offs_bytes = {{EXT_W{offs[IMM_W-1]}}, offs, {ALIGN_W{1'b0}}};
    end else begin : g_trunc
      logic [IMM_W+ALIGN_W-1:0] full_bytes;
      always_comb begin
        full_bytes = {offs, {ALIGN_W{1'b0}}};
        offs_bytes = full_bytes[ADDR_W-1:0];
      end
    end
  endgenerate

  // The sequential successor, and the branch target relative to it (both wrap)
  always_comb begin
    seq_pc = cur_pc + STEP;
    br_pc  = seq_pc + offs_bytes;
  end

  // The jump keeps the region bits of the current PC, not those of the successor
  generate
    if (PAGE_W > 0) begin : g_page
      always_comb jmp_pc = {cur_pc[ADDR_W-1 -: PAGE_W], tgt, {ALIGN_W{1'b0}}};
    end else begin : g_flat
      always_comb jmp_pc = {tgt, {ALIGN_W{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              br_sel,
  input  logic              eq,
  input  logic              jmp,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] jmp_pc,
  output logic [ADDR_W-1:0] npc
);

  npc_src_e src;
  logic     br_take;

  // A branch is taken only on the AND of the control and the flag; the jump stage comes after it
  always_comb begin
    br_take = br_sel & eq;
    src     = br_take ? NPC_BRANCH : NPC_SEQ;
    if (jmp) src = NPC_JUMP;
  end

  always_comb begin
    unique case (src)
      NPC_BRANCH: npc = br_pc;
      NPC_JUMP:   npc = jmp_pc;
      default:    npc = seq_pc;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int ADDR_W      = 32,
  parameter int IMM_W       = 16,
  parameter int TGT_W       = 26,
  parameter int ALIGN_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_sel,
  input  logic              eq,
  input  logic              jmp,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  jtarget,
  output logic [ADDR_W-1:0] pc
);

  localparam int PAGE_W = ADDR_W - TGT_W - ALIGN_W;
  localparam int EXT_W  = ADDR_W - IMM_W - ALIGN_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_W;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] jmp_pc;
  logic [ADDR_W-1:0] npc;

  npc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_targets #(
    .ADDR_W  (ADDR_W),
    .IMM_W   (IMM_W),
    .TGT_W   (TGT_W),
    .ALIGN_W (ALIGN_W)
  ) u_tgt (
    .cur_pc (pc_q),
    .offs   (imm16),
    .tgt    (jtarget),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_sel (
    .br_sel (br_sel),
    .eq     (eq),
    .jmp    (jmp),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc),
    .npc    (npc)
  );

  // Next-state process
  always_comb pc_d = npc;

  // Register process: asynchronous clear, synchronized release
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else             pc_q <= pc_d;
  end

  assign pc = pc_q;

  // R1: the PC reads zero at any edge where the reset pin is held low
  a_r1_hold_in_reset: assert property (@(posedge clk) !rst_n |-> pc == '0);

  // R2: no branch and no jump means a plain step
  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!jmp && !br_sel) |=> pc == $past(pc) + STEP);

  // R3: a taken branch adds the scaled, sign-extended offset to the successor
  a_r3_branch_taken: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_sel && eq && !jmp) |=> pc == $past(pc) + STEP +
      {{EXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), {ALIGN_W{1'b0}}});

  // R4 and R5: without the AND of control and flag, the PC only steps
  a_r4_flag_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!jmp && !(br_sel && eq)) |=> pc == $past(pc) + STEP);

  // R6 and R7: a jump overrides the branch and keeps the region of the previous PC
  a_r6_jump_splice: assert property (@(posedge clk) disable iff (!rst_sync_n)
    jmp |=> pc == {$past(pc[ADDR_W-1 -: PAGE_W]), $past(jtarget), {ALIGN_W{1'b0}}});

  // R9: the PC stays word aligned
  a_r9_word_aligned: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc[ALIGN_W-1:0] == '0);

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_sel;
  logic        eq;
  logic        jmp;
  logic [15:0] imm16;
  logic [25:0] jtarget;
  logic [31:0] pc;

  int          n_checks = 0;
  int          n_fails  = 0;
  logic [31:0] mdl_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .br_sel  (br_sel),
    .eq      (eq),
    .jmp     (jmp),
    .imm16   (imm16),
    .jtarget (jtarget),
    .pc      (pc)
  );

  // Expected next PC, written from the requirements
  function automatic logic [31:0] want_next(input logic [31:0] cur, input logic b,
                                            input logic e, input logic j,
                                            input logic [15:0] im, input logic [25:0] tg);
    logic [31:0] off;
    off = {{14{im[15]}}, im, 2'b00};
    if (j)          return {cur[31:28], tg, 2'b00};
    else if (b & e) return cur + 32'd4 + off;
    else            return cur + 32'd4;
  endfunction

  function automatic string tag_for(input logic b, input logic e, input logic j);
    if (j)      return "R6";
    if (b && e) return "R3";
    if (b)      return "R5";
    if (e)      return "R4";
    return "R2";
  endfunction

  function automatic logic [15:0] pick_imm(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'hFFFE;
      default: return 16'(k * 40503 + 977);
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: pc actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive the inputs, cross one rising edge, compare at the next falling edge
  task automatic step(input logic b, input logic e, input logic j,
                      input logic [15:0] im, input logic [25:0] tg, input string tag);
    logic [31:0] exp;
    br_sel = b; eq = e; jmp = j; imm16 = im; jtarget = tg;
    exp = want_next(mdl_pc, b, e, j, im, tg);
    @(negedge clk);
    check(pc, exp, tag);
    check({30'd0, pc[1:0]}, 32'd0, "R9");
    mdl_pc = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run actual unfinished expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; br_sel = 1'b0; eq = 1'b0; jmp = 1'b0; imm16 = '0; jtarget = '0;
    repeat (3) @(negedge clk);
    check(pc, 32'd0, "R1 held in reset");
    rst_n = 1'b1;
    @(negedge clk); check(pc, 32'd0, "R1 first edge after release");
    @(negedge clk); check(pc, 32'd0, "R1 second edge after release");
    @(negedge clk); check(pc, 32'd4, "R1 first update on third edge");
    mdl_pc = 32'd4;

    // Sweep all control combinations against boundary and spread offsets/targets (R2 R3 R4 R5 R6)
    for (int ctl = 0; ctl < 8; ctl++) begin
      for (int k = 0; k < 64; k++) begin
        step(ctl[2], ctl[1], ctl[0], pick_imm(k), 26'(k * 1234577 + ctl * 333),
             tag_for(ctl[2], ctl[1], ctl[0]));
      end
    end

    // Interleaved controls, so every kind of step follows every other
    for (int k = 0; k < 256; k++) begin
      logic [2:0] c;
      c = 3'(k * 5 + k / 8);
      step(c[2], c[1], c[0], pick_imm(k % 70), 26'(k * 7919), tag_for(c[2], c[1], c[0]));
    end

    // R1: asynchronous clear in the middle of a cycle, then a synchronized release again
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check(pc, 32'd0, "R1 asynchronous clear");
    @(negedge clk);
    br_sel = 1'b0; eq = 1'b0; jmp = 1'b0;
    rst_n = 1'b1;
    @(negedge clk); check(pc, 32'd0, "R1 re-release edge one");
    @(negedge clk); check(pc, 32'd0, "R1 re-release edge two");
    mdl_pc = 32'd0;
    step(1'b0, 1'b0, 1'b0, 16'h0, 26'h0, "R1 first step after re-release");

    // R8: a backward branch below zero wraps
    step(1'b1, 1'b1, 1'b0, 16'h8000, 26'h0, "R8 branch wrap");
    check(pc, 32'hFFFE0008, "R8 branch wrap value");
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h3FFFFFF, "R6 jump to top of region");
    check(pc, 32'hFFFFFFFC, "R6 top address");
    step(1'b1, 1'b1, 1'b0, 16'h0001, 26'h0, "R8 forward branch wrap");
    check(pc, 32'h00000004, "R8 forward branch wrap value");
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h3FFFFFF, "R6 region end");
    step(1'b0, 1'b1, 1'b0, 16'h1234, 26'h0, "R4 step past region end");
    check(pc, 32'h10000000, "R8 sequential into next region");
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h3FFFFFF, "R6 back to region end");
    check(pc, 32'h1FFFFFFC, "R6 region one end");
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h3FFFFFF, "R6 stay");
    step(1'b0, 1'b0, 1'b1, 16'h0, 26'h0000005, "R7 region from current PC");
    check(pc, 32'h10000014, "R7 region from current PC value");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule